// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of an 8-bit successive-approximation analog-to-digital converter. A host raises a CONVERT request line and later drops it. The rising edge clears the result and forces the active-low data-ready output high. The falling edge starts a conversion, but only if the line stayed high for a qualified number of clock cycles. The request line is asynchronous, so it passes through a multi-flop synchroniser, and both of its edges are detected on the internal clock.

During a conversion the sequencer drives a trial code to an external DAC and reads back one comparator bit. It tests one bit per clock, starting at the most significant bit. When the last bit has been decided, data-ready goes low and the code is held until the next request. The output bus is gated by an active-low enable. The high-impedance state is modelled as a separate output-enable signal next to a bus that reads zero while disabled.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, `ready_n_o` is 1, `trial_o` is zero and no conversion is running.
- R2: A rising edge on `convert_i` clears `trial_o` to zero and makes `ready_n_o` 1 within READY_MAX_CYC (4) clock cycles. With the two-stage synchroniser this takes 3 cycles.
- R3: If `convert_i` stays high for fewer than MIN_PULSE cycles before it falls, no conversion starts. `ready_n_o` stays 1 and `trial_o` stays zero. A pulse of exactly MIN_PULSE cycles is accepted.
- R4: A conversion first applies the code with only bit 7 set (0x80). This happens 3 cycles after `convert_i` falls.
- R5: Each bit under trial is set first. It is cleared when `cmp_i` is 1 (DAC sum above the input) and kept when `cmp_i` is 0. For an input level V where `cmp_i` = (trial > V), the final code equals V for every V in 0..255.
- R6: `ready_n_o` goes low only at the end of a conversion, WIDTH cycles after the MSB is applied. That is 11 cycles after `convert_i` falls.
- R7: After completion, the code and `ready_n_o` = 0 hold until the next rising edge of `convert_i`. Changes on `cmp_i` have no effect.
- R8: A rising edge of `convert_i` during a conversion aborts it. `ready_n_o` returns to 1, the code is cleared, and the next qualified falling edge starts a fresh conversion.
- R9: `data_oe_o` is the inverse of `oe_n_i`. When it is 1, `data_o` equals the held code. When it is 0, `data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| convert_i | input | 1 | Asynchronous conversion request; rising edge clears, falling edge starts |
| cmp_i | input | 1 | Comparator result, 1 when the DAC sum exceeds the input |
| oe_n_i | input | 1 | Active-low output enable for the data bus |
| trial_o | output | WIDTH | Code driven to the DAC; holds the result after completion |
| ready_n_o | output | 1 | Active-low data-ready |
| data_o | output | WIDTH | Gated result bus, zero while disabled |
| data_oe_o | output | 1 | Bus drive enable, 1 while `oe_n_i` is low |

## Verification
The assertions check on every cycle the following properties:
- A detected request edge clears the code and raises data-ready.
- A falling edge that fails qualification starts nothing.
- A conversion starts with only the MSB set.
- Each decision moves the count of set bits in the direction the comparator dictates.
- Data-ready falls only out of a running conversion.
- A completed code holds.
- The bus follows its enable.

Only the bench scenarios can show the rest:
- The exact latencies from the request pin.
- That the final code equals the input for all 256 input levels.
- The boundary between a rejected pulse and an accepted one.
- That an aborted conversion is followed by a correct fresh one.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARM    = 2'd1,
        ST_DECIDE = 2'd2,
        ST_DONE   = 2'd3
    } sar_state_e;

endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t r_q, r_d;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                r_d          = r_q;
                r_d.chain[0] = async_i;
                r_d.prev     = r_q.chain[0];
            end
        end else begin : g_multi
            always_comb begin
                r_d       = r_q;
                r_d.chain = {r_q.chain[STAGES-2:0], async_i};
                r_d.prev  = r_q.chain[STAGES-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign level_o = r_q.chain[STAGES-1];
    assign rise_o  = r_q.chain[STAGES-1] & ~r_q.prev;
    assign fall_o  = ~r_q.chain[STAGES-1] & r_q.prev;

endmodule

// File: rtl/sar_pulse_qual.sv
module sar_pulse_qual #(
    parameter int MIN_PULSE = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic rise_i,
    output logic long_enough_o
);
    localparam int CW = $clog2(MIN_PULSE + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (rise_i) begin
            cnt_d = CW'(1);
        end else if (level_i && (cnt_q < CW'(MIN_PULSE))) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign long_enough_o = (cnt_q >= CW'(MIN_PULSE));

endmodule

// File: rtl/sar_core.sv
module sar_core
    import sar_conv_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             pulse_ok_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] trial_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    typedef struct packed {
        sar_state_e       st;
        logic [WIDTH-1:0] trial;
        logic [IW-1:0]    idx;
    } core_t;

    core_t r_q, r_d;
    logic [WIDTH-1:0] t_work;

    always_comb begin
        r_d    = r_q;
        t_work = r_q.trial;
        if (rise_i) begin
            r_d.st    = ST_ARM;
            r_d.trial = '0;
            r_d.idx   = '0;
        end else begin
            case (r_q.st)
                ST_ARM: begin
                    if (fall_i) begin
                        if (pulse_ok_i) begin
                            r_d.st           = ST_DECIDE;
                            r_d.trial        = '0;
                            r_d.trial[WIDTH-1] = 1'b1;
                            r_d.idx          = IW'(WIDTH - 1);
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                ST_DECIDE: begin
                    if (cmp_i) begin
                        t_work[r_q.idx] = 1'b0;
                    end
                    if (r_q.idx == '0) begin
                        r_d.st = ST_DONE;
                    end else begin
                        t_work[r_q.idx - IW'(1)] = 1'b1;
                        r_d.idx = r_q.idx - IW'(1);
                    end
                    r_d.trial = t_work;
                end
                default: begin
                    r_d = r_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.trial <= '0;
            r_q.idx   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign trial_o = r_q.trial;
    assign busy_o  = (r_q.st == ST_DECIDE);
    assign done_o  = (r_q.st == ST_DONE);

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
    parameter int WIDTH       = 8,
    parameter int MIN_PULSE   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             convert_i,
    input  logic             cmp_i,
    input  logic             oe_n_i,
    output logic [WIDTH-1:0] trial_o,
    output logic             ready_n_o,
    output logic [WIDTH-1:0] data_o,
    output logic             data_oe_o
);
    logic conv_level;
    logic conv_rise;
    logic conv_fall;
    logic pulse_ok;
    logic busy;
    logic done;

    sar_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (convert_i),
        .level_o (conv_level),
        .rise_o  (conv_rise),
        .fall_o  (conv_fall)
    );

    sar_pulse_qual #(.MIN_PULSE(MIN_PULSE)) qual_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .level_i       (conv_level),
        .rise_i        (conv_rise),
        .long_enough_o (pulse_ok)
    );

    sar_core #(.WIDTH(WIDTH)) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (conv_rise),
        .fall_i     (conv_fall),
        .pulse_ok_i (pulse_ok),
        .cmp_i      (cmp_i),
        .trial_o    (trial_o),
        .busy_o     (busy),
        .done_o     (done)
    );

    assign ready_n_o = ~done;
    assign data_oe_o = ~oe_n_i;
    assign data_o    = oe_n_i ? '0 : trial_o;

endmodule

// File: rtl/sar_conv_checker.sv
module sar_conv_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_rise,
    input logic             conv_fall,
    input logic             pulse_ok,
    input logic             busy,
    input logic             cmp_i,
    input logic             ready_n_o,
    input logic [WIDTH-1:0] trial_o,
    input logic [WIDTH-1:0] data_o,
    input logic             data_oe_o
);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    p_rise_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_rise |=> (ready_n_o && (trial_o == '0)));

    p_short_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_fall && !pulse_ok) |=> (ready_n_o && !busy));

    p_msb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_fall && pulse_ok) |=> (busy && (trial_o == MSB_ONLY)));

    p_clear_no_growth_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmp_i && !conv_rise) |=>
            ($countones(trial_o) <= $countones($past(trial_o))));

    p_keep_no_shrink_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmp_i && !conv_rise) |=>
            ($countones(trial_o) >= $countones($past(trial_o))));

    p_ready_from_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_n_o) |-> $past(busy));

    p_hold_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_n_o && !conv_rise) |=> (!ready_n_o && $stable(trial_o)));

    p_bus_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> (data_o == trial_o));

    p_bus_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe_o |-> (data_o == '0));

endmodule

bind sar_conv_ctrl sar_conv_checker #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_rise (conv_rise),
    .conv_fall (conv_fall),
    .pulse_ok  (pulse_ok),
    .busy      (busy),
    .cmp_i     (cmp_i),
    .ready_n_o (ready_n_o),
    .trial_o   (trial_o),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
);

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb_top;
    localparam int W         = 8;
    localparam int MINP      = 5;
    localparam int READY_MAX = 4;
    localparam int T_MSB     = 3;
    localparam int T_DONE    = 3 + W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         convert = 1'b0;
    logic         oe_n = 1'b0;
    int           vin = 0;
    logic [W-1:0] trial;
    logic         ready_n;
    logic [W-1:0] data;
    logic         data_oe;
    logic         cmp;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign cmp = (int'(trial) > vin);

    sar_conv_ctrl #(.WIDTH(W), .MIN_PULSE(MINP), .SYNC_STAGES(2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .convert_i (convert),
        .cmp_i     (cmp),
        .oe_n_i    (oe_n),
        .trial_o   (trial),
        .ready_n_o (ready_n),
        .data_o    (data),
        .data_oe_o (data_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pulse high for hi cycles, then low; returns latency to ready low and MSB code seen.
    task automatic run_conv(input int v, input int hi, output int lat, output int t_msb);
        vin = v;
        @(negedge clk) convert = 1'b1;
        repeat (hi) @(negedge clk);
        convert = 1'b0;
        lat = 0;
        t_msb = -1;
        do begin
            @(negedge clk);
            lat++;
            if (lat == T_MSB) t_msb = int'(trial);
        end while (ready_n && lat < 60);
    endtask

    initial begin
        #1500000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int lat;
        int tm;
        int rl;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ready_n", int'(ready_n), 1);
        check("R1 trial", int'(trial), 0);
        check("R1 data", int'(data), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 ready_n after release", int'(ready_n), 1);

        // R4/R6 first conversion
        run_conv(8'hA5, MINP, lat, tm);
        check("R4 MSB trial", tm, 8'h80);
        check("R6 latency", lat, T_DONE);
        check("R5 result A5", int'(data), 8'hA5);

        // R7 hold with comparator changing
        vin = 0;
        repeat (30) @(negedge clk);
        check("R7 held code", int'(data), 8'hA5);
        check("R7 ready_n held", int'(ready_n), 0);
        vin = 255;
        repeat (5) @(negedge clk);
        check("R7 held code cmp low", int'(data), 8'hA5);

        // R9 gating
        oe_n = 1'b1;
        #1;
        check("R9 oe off", int'(data_oe), 0);
        check("R9 bus zero", int'(data), 0);
        oe_n = 1'b0;
        #1;
        check("R9 oe on", int'(data_oe), 1);
        check("R9 bus value", int'(data), 8'hA5);

        // R2 rise latency
        @(negedge clk) convert = 1'b1;
        rl = 0;
        do begin
            @(negedge clk);
            rl++;
        end while (!ready_n && rl < 20);
        check("R2 ready high latency", rl, 3);
        check("R2 latency bound", int'(rl <= READY_MAX), 1);
        check("R2 cleared", int'(trial), 0);
        repeat (MINP) @(negedge clk);
        convert = 1'b0;
        repeat (T_DONE + 2) @(negedge clk);

        // R3 short pulse rejected
        run_conv(8'h3C, MINP - 1, lat, tm);
        check("R3 short no ready", int'(ready_n), 1);
        check("R3 short code zero", int'(trial), 0);
        repeat (20) @(negedge clk);
        check("R3 short still idle", int'(ready_n), 1);
        check("R3 short bus zero", int'(data), 0);
        // R3 exact minimum accepted
        run_conv(8'h3C, MINP, lat, tm);
        check("R3 min pulse accepted", lat, T_DONE);
        check("R3 min pulse code", int'(data), 8'h3C);

        // R8 abort mid-conversion
        vin = 8'h77;
        @(negedge clk) convert = 1'b1;
        repeat (MINP) @(negedge clk);
        convert = 1'b0;
        repeat (T_MSB + 3) @(negedge clk);
        check("R8 busy before abort", int'(ready_n), 1);
        convert = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 code cleared", int'(trial), 0);
        repeat (T_DONE + 4) @(negedge clk);
        check("R8 no completion while high", int'(ready_n), 1);
        convert = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (ready_n && lat < 60);
        check("R8 restart latency", lat, T_DONE);
        check("R8 restart code", int'(data), 8'h77);

        // R5/R6 exhaustive sweep
        for (int v = 0; v < (1 << W); v++) begin
            run_conv(v, MINP + (v % 3), lat, tm);
            check("R5 sweep code", int'(data), v);
            check("R6 sweep latency", lat, T_DONE);
            check("R4 sweep msb", tm, 8'h80);
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule